// File: doc/BRIEF.md
# Line Buffer 3x3 Window Generator

This block takes a raster stream of single-plane pixels through a ready/valid handshake. For every pixel position of the frame it produces the 3x3 neighbourhood centred on that position. Two line buffers hold the earlier rows, and a three-column shift register builds the window. Where a neighbour lies outside the frame, the block fills it according to a border policy: replicate the nearest edge pixel, reflect about the edge, or use a constant.

Frame width, frame height, border policy and fill constant are inputs. The block samples them on the first pixel of each frame. A frame-start flag marks the pixel at row 0, column 0, and a second start flag goes out with the window centred there. The stream may stall at any cycle. Because the window is centred, the window for a position comes out only after the pixel one row and one column further on has arrived. After the last pixel of a frame, the block lowers ready for one row plus one cycle and emits the last windows itself.

Top module: `wgen_window3`

## Requirements
- R1: After reset `in_ready` is 1 and `out_valid` is 0. A pixel is taken on a rising edge where `in_valid` and `in_ready` are both 1.
- R2: A pixel taken at raster index k produces the window centred on index k-W-1, for each k >= W+1 (W is the frame width). `out_valid` is high for exactly one cycle, two rising edges after the accepting edge.
- R3: `out_win[(3*r+c)*DW +: DW]` holds the neighbour at row offset r-1 and column offset c-1 from the centre, for r and c from 0 to 2.
- R4: Border code 0 (and 3) replicates: a neighbour outside the frame takes the value of the nearest pixel inside the frame.
- R5: Border code 1 reflects: a neighbour one step outside an edge takes the value of the pixel one step inside that edge, on each axis.
- R6: Border code 2 fills every neighbour outside the frame with `cfg_fill`.
- R7: `out_sof` is 1 together with `out_valid` only on the window centred on row 0, column 0.
- R8: After the final pixel of a frame is taken, `in_ready` stays 0 for exactly W+1 cycles. During those cycles the remaining W+1 windows come out, the last centred on the bottom-right pixel.
- R9: Cycles with `in_valid` low change nothing: the windows equal those of the same stream with no gaps, and `out_valid` stays 0 three cycles after the last stepping cycle.
- R10: A pixel taken with `in_sof` at 1 becomes row 0, column 0 of a new frame, even in the middle of a frame.
- R11: `cfg_width` (3 to MAX_W), `cfg_height` (3 to MAX_H), `cfg_mode` and `cfg_fill` are sampled only with the first pixel of a frame. Values on them during later pixels have no effect on that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Pixel present |
| in_ready | output | 1 | Block can take a pixel |
| in_sof | input | 1 | Pixel is row 0, column 0 |
| in_pix | input | DW | Pixel value |
| cfg_width | input | $clog2(MAX_W+1) | Frame width in pixels |
| cfg_height | input | $clog2(MAX_H+2) | Frame height in rows |
| cfg_mode | input | 2 | Border code: 0 replicate, 1 reflect, 2 constant, 3 replicate |
| cfg_fill | input | DW | Constant for border code 2 |
| out_valid | output | 1 | Window valid for one cycle |
| out_sof | output | 1 | Window is centred on row 0, column 0 |
| out_win | output | 9*DW | Neighbourhood, row-major, top-left in the low bits |

## Verification
The bench runs frames of different sizes under each border code. A smallest 3x3 frame checks every border at once, and a 200x100 frame checks long rows. Streams run without gaps, with random gaps and in bursts, so stalls can be told apart from missing data. Scrambled configuration values on non-first pixels show that settings are taken only at frame start. A frame cut short by a new frame start checks that counters restart. The bench compares every cycle against a per-window model that builds each neighbourhood from the stored frame image, so it can detect a wrong border substitution, a wrong window lag or a wrong flush length.

// File: rtl/wgen_pkg.sv
package wgen_pkg;
  typedef enum logic [1:0] {
    BM_COPY   = 2'd0,
    BM_MIRROR = 2'd1,
    BM_FILL   = 2'd2,
    BM_COPY2  = 2'd3
  } bmode_e;

  // Border situation of the window centre carried with each step.
  typedef struct packed {
    logic ok;   // centre lies inside the frame
    logic sof;  // centre is row 0, column 0
    logic top;  // centre on first row
    logic bot;  // centre on last row
    logic lft;  // centre on first column
    logic rgt;  // centre on last column
  } cflags_t;
endpackage

// File: rtl/wgen_ctrl.sv
module wgen_ctrl
  import wgen_pkg::*;
#(
  parameter int DW    = 8,
  parameter int MAX_W = 2048,
  parameter int MAX_H = 2048,
  localparam int CW   = $clog2(MAX_W + 1),
  localparam int RW   = $clog2(MAX_H + 2)
) (
  input  logic          clk,
  input  logic          rst_ni,
  input  logic          in_valid,
  input  logic          in_sof,
  input  logic [CW-1:0] cfg_width,
  input  logic [RW-1:0] cfg_height,
  input  logic [1:0]    cfg_mode,
  input  logic [DW-1:0] cfg_fill,
  output logic          in_ready,
  output logic          step,
  output logic          dummy,
  output logic [CW-1:0] pos_c,
  output cflags_t       flags,
  output bmode_e        mode,
  output logic [DW-1:0] fill
);
  logic          en_q, flush_q, flush_d;
  logic [CW-1:0] col_q, col_d, w_q, w_d, eff_w;
  logic [RW-1:0] row_q, row_d, h_q, h_d, eff_h, pos_r;
  bmode_e        mode_q, mode_d;
  logic [DW-1:0] fill_q, fill_d;
  logic          accept, start, c0;

  assign in_ready = en_q && !flush_q;
  assign accept   = in_valid && in_ready;
  assign start    = accept && (in_sof || (row_q == '0 && col_q == '0));
  assign step     = accept || flush_q;
  assign dummy    = !accept;

  assign eff_w = start ? cfg_width  : w_q;
  assign eff_h = start ? cfg_height : h_q;
  assign pos_r = start ? '0 : row_q;
  assign pos_c = start ? '0 : col_q;
  assign mode  = start ? bmode_e'(cfg_mode) : mode_q;
  assign fill  = start ? cfg_fill : fill_q;
  assign c0    = (pos_c == '0);

  // Flags describe the centre, one row and one column behind the input.
  always_comb begin
    flags.ok  = c0 ? (pos_r >= RW'(2)) : (pos_r >= RW'(1));
    flags.sof = (pos_r == RW'(1)) && (pos_c == CW'(1));
    flags.top = c0 ? (pos_r == RW'(2)) : (pos_r == RW'(1));
    flags.bot = c0 ? (pos_r == eff_h + RW'(1)) : (pos_r == eff_h);
    flags.lft = (pos_c == CW'(1));
    flags.rgt = c0;
  end

  always_comb begin
    flush_d = flush_q;
    col_d   = col_q;
    row_d   = row_q;
    w_d     = w_q;
    h_d     = h_q;
    mode_d  = mode_q;
    fill_d  = fill_q;
    if (start) begin
      w_d    = cfg_width;
      h_d    = cfg_height;
      mode_d = bmode_e'(cfg_mode);
      fill_d = cfg_fill;
    end
    if (step) begin
      if (pos_c == eff_w - CW'(1)) begin
        col_d = '0;
        row_d = pos_r + RW'(1);
      end else begin
        col_d = pos_c + CW'(1);
        row_d = pos_r;
      end
      if (accept && pos_r == eff_h - RW'(1) && pos_c == eff_w - CW'(1)) begin
        flush_d = 1'b1;
      end
      if (flush_q && row_q == h_q + RW'(1)) begin
        flush_d = 1'b0;
        col_d   = '0;
        row_d   = '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q    <= 1'b0;
      flush_q <= 1'b0;
      col_q   <= '0;
      row_q   <= '0;
      w_q     <= '0;
      h_q     <= '0;
      mode_q  <= BM_COPY;
      fill_q  <= '0;
    end else begin
      en_q    <= 1'b1;
      flush_q <= flush_d;
      col_q   <= col_d;
      row_q   <= row_d;
      w_q     <= w_d;
      h_q     <= h_d;
      mode_q  <= mode_d;
      fill_q  <= fill_d;
    end
  end
endmodule

// File: rtl/wgen_linebuf.sv
module wgen_linebuf #(
  parameter int DW    = 8,
  parameter int DEPTH = 2048,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic            clk,
  input  logic            rd_en,
  input  logic [AW-1:0]   rd_addr,
  output logic [2*DW-1:0] rd_data,
  input  logic            wr_en,
  input  logic [AW-1:0]   wr_addr,
  input  logic [2*DW-1:0] wr_data
);
  // Both earlier rows share one word per column.
  logic [2*DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rd_en) rd_data <= mem[rd_addr];
  end
endmodule

// File: rtl/wgen_border.sv
module wgen_border
  import wgen_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic [9*DW-1:0] win_i,
  input  cflags_t         flags,
  input  bmode_e          mode,
  input  logic [DW-1:0]   fill,
  output logic [9*DW-1:0] win_o
);
  logic [DW-1:0] w [3][3];
  logic [DW-1:0] x [3][3];
  logic [DW-1:0] y [3][3];
  logic          mir, fil;

  assign mir = (mode == BM_MIRROR);
  assign fil = (mode == BM_FILL);

  always_comb begin
    for (int r = 0; r < 3; r++) begin
      for (int c = 0; c < 3; c++) w[r][c] = win_i[(3*r+c)*DW +: DW];
    end
    // Horizontal pass.
    for (int r = 0; r < 3; r++) begin
      x[r][1] = w[r][1];
      x[r][0] = !flags.lft ? w[r][0] : fil ? fill : mir ? w[r][2] : w[r][1];
      x[r][2] = !flags.rgt ? w[r][2] : fil ? fill : mir ? w[r][0] : w[r][1];
    end
    // Vertical pass on the horizontally fixed rows.
    for (int c = 0; c < 3; c++) begin
      y[1][c] = x[1][c];
      y[0][c] = !flags.top ? x[0][c] : fil ? fill : mir ? x[2][c] : x[1][c];
      y[2][c] = !flags.bot ? x[2][c] : fil ? fill : mir ? x[0][c] : x[1][c];
    end
    for (int r = 0; r < 3; r++) begin
      for (int c = 0; c < 3; c++) win_o[(3*r+c)*DW +: DW] = y[r][c];
    end
  end
endmodule

// File: rtl/wgen_window3.sv
module wgen_window3
  import wgen_pkg::*;
#(
  parameter int DW    = 8,
  parameter int MAX_W = 2048,
  parameter int MAX_H = 2048,
  localparam int CW   = $clog2(MAX_W + 1),
  localparam int RW   = $clog2(MAX_H + 2),
  localparam int AW   = $clog2(MAX_W)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic            in_sof,
  input  logic [DW-1:0]   in_pix,
  input  logic [CW-1:0]   cfg_width,
  input  logic [RW-1:0]   cfg_height,
  input  logic [1:0]      cfg_mode,
  input  logic [DW-1:0]   cfg_fill,
  output logic            out_valid,
  output logic            out_sof,
  output logic [9*DW-1:0] out_win
);
  logic [1:0]      rs_q;
  logic            rst_i;
  logic            step, dummy;
  logic [CW-1:0]   pos_c;
  cflags_t         st_flags, s1_fl_q, s2_fl_q;
  bmode_e          st_mode, s1_mode_q, s2_mode_q;
  logic [DW-1:0]   st_fill, s1_fill_q, s2_fill_q;
  logic            s1_v_q, s2_v_q;
  logic [DW-1:0]   s1_pix_q;
  logic [AW-1:0]   s1_col_q;
  logic [2*DW-1:0] rd_data;
  logic [3*DW-1:0] col_vec;
  logic [9*DW-1:0] win_flat, fixed_win;

  // Asynchronous assertion, synchronous release.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_i = rs_q[1];

  wgen_ctrl #(.DW(DW), .MAX_W(MAX_W), .MAX_H(MAX_H)) u_ctrl (
    .clk(clk), .rst_ni(rst_i), .in_valid(in_valid), .in_sof(in_sof),
    .cfg_width(cfg_width), .cfg_height(cfg_height), .cfg_mode(cfg_mode),
    .cfg_fill(cfg_fill), .in_ready(in_ready), .step(step), .dummy(dummy),
    .pos_c(pos_c), .flags(st_flags), .mode(st_mode), .fill(st_fill)
  );

  wgen_linebuf #(.DW(DW), .DEPTH(MAX_W)) u_lbuf (
    .clk(clk), .rd_en(step), .rd_addr(pos_c[AW-1:0]), .rd_data(rd_data),
    .wr_en(s1_v_q), .wr_addr(s1_col_q),
    .wr_data({s1_pix_q, rd_data[2*DW-1:DW]})
  );

  // Stage 1: pixel and line buffer read.
  always_ff @(posedge clk) begin
    if (step) begin
      s1_pix_q  <= dummy ? '0 : in_pix;
      s1_col_q  <= pos_c[AW-1:0];
      s1_fl_q   <= st_flags;
      s1_mode_q <= st_mode;
      s1_fill_q <= st_fill;
    end
  end

  // Column entering the window: oldest row at the top.
  assign col_vec = {s1_pix_q, rd_data[2*DW-1:DW], rd_data[DW-1:0]};

  // Stage 2: three-column shift per window row.
  for (genvar r = 0; r < 3; r++) begin : g_row
    logic [3*DW-1:0] row_q;
    always_ff @(posedge clk) begin
      if (s1_v_q) row_q <= {col_vec[r*DW +: DW], row_q[3*DW-1:DW]};
    end
    assign win_flat[3*r*DW +: 3*DW] = row_q;
  end

  always_ff @(posedge clk) begin
    if (s1_v_q) begin
      s2_fl_q   <= s1_fl_q;
      s2_mode_q <= s1_mode_q;
      s2_fill_q <= s1_fill_q;
    end
  end

  wgen_border #(.DW(DW)) u_border (
    .win_i(win_flat), .flags(s2_fl_q), .mode(s2_mode_q),
    .fill(s2_fill_q), .win_o(fixed_win)
  );

  // Stage 3: registered window out.
  always_ff @(posedge clk) begin
    if (s2_v_q) out_win <= fixed_win;
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      s1_v_q    <= 1'b0;
      s2_v_q    <= 1'b0;
      out_valid <= 1'b0;
      out_sof   <= 1'b0;
    end else begin
      s1_v_q    <= step;
      s2_v_q    <= s1_v_q;
      out_valid <= s2_v_q && s2_fl_q.ok;
      out_sof   <= s2_v_q && s2_fl_q.ok && s2_fl_q.sof;
    end
  end
endmodule

// File: rtl/wgen_window3_chk.sv
module wgen_window3_chk #(
  parameter int MAX_W = 2048,
  localparam int LW   = $clog2(MAX_W + 8) + 1
) (
  input logic clk,
  input logic rst_n,
  input logic in_valid,
  input logic in_ready,
  input logic out_valid,
  input logic out_sof
);
  logic [LW-1:0] lo_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              lo_cnt <= '0;
    else if (in_ready)       lo_cnt <= '0;
    else if (lo_cnt != '1)   lo_cnt <= lo_cnt + LW'(1);
  end

  AST_SOF_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    out_sof |-> out_valid); // R7

  AST_READY_FALLS_AFTER_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(in_ready) |-> $past(in_valid)); // R8

  AST_FLUSH_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
    lo_cnt <= LW'(MAX_W + 3)); // R8

  AST_OUT_FOLLOWS_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past((in_valid && in_ready) || !in_ready, 3)); // R2

  AST_QUIET_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(in_ready && !in_valid, 1) && $past(in_ready && !in_valid, 2) &&
     $past(in_ready && !in_valid, 3)) |-> !out_valid); // R9
endmodule

bind wgen_window3 wgen_window3_chk #(.MAX_W(MAX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_sof(out_sof)
);

// File: tb/wgen_window3_bench.sv
module wgen_window3_bench;
  localparam int DW    = 8;
  localparam int MAX_W = 2048;
  localparam int MAX_H = 2048;
  localparam int CW    = $clog2(MAX_W + 1);
  localparam int RW    = $clog2(MAX_H + 2);

  logic            clk = 1'b0;
  logic            rst_n;
  logic            in_valid, in_ready, in_sof;
  logic [DW-1:0]   in_pix;
  logic [CW-1:0]   cfg_width;
  logic [RW-1:0]   cfg_height;
  logic [1:0]      cfg_mode;
  logic [DW-1:0]   cfg_fill;
  logic            out_valid, out_sof;
  logic [9*DW-1:0] out_win;

  wgen_window3 #(.DW(DW), .MAX_W(MAX_W), .MAX_H(MAX_H)) u_wgen_window3 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_sof(in_sof), .in_pix(in_pix), .cfg_width(cfg_width),
    .cfg_height(cfg_height), .cfg_mode(cfg_mode), .cfg_fill(cfg_fill),
    .out_valid(out_valid), .out_sof(out_sof), .out_win(out_win)
  );

  always #10 clk = ~clk;

  int n_tests = 0;
  int n_fail  = 0;
  bit started = 0;
  bit done    = 0;
  string phase = "R2";

  task automatic check(bit ok, string req, string what, logic [71:0] act, logic [71:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s (%s): actual %h expected %h", req, phase, what, act, exp);
    end
  endtask

  // Behavioural model state.
  int cyc = 0;
  int k = 0, mflush = 0;
  int fw = 0, fh = 0, fmode = 0, ffill = 0;
  int img [0:20999];
  int          due_q [$];
  bit          sof_q [$];
  logic [71:0] win_q [$];
  int          tag_q [$];

  function automatic int pick(int v, int lim, bit mir);
    if (v < 0)    return mir ? 1 : 0;
    if (v >= lim) return mir ? lim - 2 : lim - 1;
    return v;
  endfunction

  task automatic emit(int idx);
    int m, cr, cc;
    logic [71:0] w;
    bit brd;
    m = idx - fw - 1;
    if (m < 0 || m > fw * fh - 1) return;
    cr = m / fw;
    cc = m % fw;
    brd = 0;
    for (int dr = -1; dr <= 1; dr++) begin
      for (int dc = -1; dc <= 1; dc++) begin
        int rr, ccc, v;
        bit outside;
        rr = cr + dr;
        ccc = cc + dc;
        outside = (rr < 0 || rr >= fh || ccc < 0 || ccc >= fw);
        if (outside) brd = 1;
        if (outside && fmode == 2) v = ffill;
        else v = img[pick(rr, fh, fmode == 1) * fw + pick(ccc, fw, fmode == 1)];
        w[((dr + 1) * 3 + (dc + 1)) * 8 +: 8] = v[7:0];
      end
    end
    due_q.push_back(cyc + 2);
    sof_q.push_back(m == 0);
    win_q.push_back(w);
    tag_q.push_back(brd ? (fmode == 1 ? 5 : fmode == 2 ? 6 : 4) : 3);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      k = 0;
      mflush = 0;
    end else if (started) begin
      if (in_valid && mflush == 0) begin
        if (in_sof || k == 0) begin
          k = 0;
          fw = int'(cfg_width);
          fh = int'(cfg_height);
          fmode = int'(cfg_mode);
          ffill = int'(cfg_fill);
        end
        img[k] = int'(in_pix);
        emit(k);
        if (k == fw * fh - 1) mflush = fw + 1;
        k++;
      end else if (mflush > 0) begin
        emit(k);
        k++;
        mflush--;
        if (mflush == 0) k = 0;
      end
    end
  end

  // Output comparison away from the active edge.
  always @(negedge clk) begin
    if (started && !done) begin
      bit exp;
      check(in_ready == (mflush == 0), (mflush == 0) ? "R1" : "R8", "in_ready",
            72'(in_ready), 72'(mflush == 0));
      exp = (due_q.size() > 0) && (due_q[0] == cyc);
      check(out_valid == exp, "R2", "out_valid", 72'(out_valid), 72'(exp));
      if (exp) begin
        string t;
        case (tag_q[0])
          3: t = "R3";
          4: t = "R4";
          5: t = "R5";
          default: t = "R6";
        endcase
        if (out_valid) begin
          check(out_sof == sof_q[0], "R7", "out_sof", 72'(out_sof), 72'(sof_q[0]));
          check(out_win == win_q[0], t, "window", out_win, win_q[0]);
        end
        void'(due_q.pop_front());
        void'(sof_q.pop_front());
        void'(win_q.pop_front());
        void'(tag_q.pop_front());
      end
    end
  end

  task automatic drive_pix(bit sof, int w, int h, int mode, int fill, int stall);
    @(negedge clk);
    while (int'($urandom % 100) < stall) begin
      in_valid = 1'b0;
      @(negedge clk);
    end
    in_valid = 1'b1;
    in_pix   = DW'($urandom);
    in_sof   = sof;
    if (sof) begin
      cfg_width  = CW'(w);
      cfg_height = RW'(h);
      cfg_mode   = 2'(mode);
      cfg_fill   = DW'(fill);
    end else begin
      // R11: these must be ignored mid-frame
      cfg_width  = CW'(3 + $urandom % 9);
      cfg_height = RW'(3 + $urandom % 9);
      cfg_mode   = 2'($urandom);
      cfg_fill   = DW'($urandom);
    end
    while (!in_ready) @(negedge clk);
    @(posedge clk);
  endtask

  task automatic send_frame(int w, int h, int mode, int fill, int stall, int npix);
    int n;
    n = (npix < 0) ? w * h : npix;
    for (int i = 0; i < n; i++) drive_pix(i == 0, w, h, mode, fill, stall);
  endtask

  task automatic idle(int n);
    @(negedge clk);
    in_valid = 1'b0;
    in_sof   = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: run did not complete");
      finish_run();
    end
  end

  initial begin
    rst_n = 1'b0;
    in_valid = 1'b0;
    in_sof = 1'b0;
    in_pix = '0;
    cfg_width = '0;
    cfg_height = '0;
    cfg_mode = '0;
    cfg_fill = '0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    phase = "R1";
    check(in_ready == 1'b1, "R1", "reset ready", 72'(in_ready), 72'(1));
    check(out_valid == 1'b0, "R1", "reset valid", 72'(out_valid), 72'(0));
    check(out_sof == 1'b0, "R7", "reset sof", 72'(out_sof), 72'(0));
    started = 1;

    phase = "R4 copy gapless";
    send_frame(5, 4, 0, 0, 0, -1);
    phase = "R5 mirror stalls R9";
    send_frame(6, 5, 1, 0, 40, -1);
    phase = "R6 fill bursts";
    send_frame(4, 3, 2, 8'hA5, 15, -1);
    idle(20);
    phase = "R9 idle gaps";
    send_frame(3, 3, 1, 0, 70, -1);
    phase = "R10 cut frame";
    send_frame(7, 5, 0, 0, 10, 20);
    phase = "R10 restart";
    send_frame(5, 4, 1, 0, 0, -1);
    phase = "R4 code three";
    send_frame(3, 3, 3, 8'h11, 0, -1);
    phase = "R6 smallest";
    send_frame(3, 3, 2, 8'h3C, 0, -1);
    phase = "R11 wide";
    send_frame(200, 100, 0, 0, 0, -1);
    phase = "R8 tail";
    idle(400);
    check(due_q.size() == 0, "R8", "windows left", 72'(due_q.size()), 72'(0));
    done = 1;
    finish_run();
  end
endmodule